// File: doc/BRIEF.md
# Refresh-Aware Read Queue Sequencer

This block decides, for each DRAM rank on its own, how a due refresh is brought in so that reads lose as little as possible. When a rank's refresh falls due, the sequencer first opens a window in which prefetch streams aimed at that rank may run further ahead than usual. Once that window closes, it shuts the read queue's entry for the rank, so neither prefetches nor cache misses are admitted. It then asks the read scheduler to empty that rank's queued reads at high priority. Only when the rank's occupancy reaches zero does it raise a refresh request toward the command issuer.

After the issuer accepts the refresh, the rank is marked busy for a programmable number of cycles, and no read or write may be issued to it during that time. The admission gate opens again when the busy time ends. One quiet recovery cycle follows. If another refresh fell due while the sequence was running, it is kept as a single pending request and starts a fresh sequence after the recovery cycle.

The read queue reports its occupancy for every rank. The prefetch engine, the read scheduler and the command issuer act on the per-rank outputs. DRAM timing rules are enforced elsewhere.

Top module: `refresh_read_sequencer`

## Requirements
- R1: During reset and in the cycle after reset is released, all per-rank outputs are low.
- R2: A refresh_due pulse seen on a clock edge while the rank is idle raises stream_extend from the next cycle. It stays high for max(extend_cycles,1) cycles.
- R3: While stream_extend is high, admit_block stays low. The cycle after the extension window ends, admit_block and drain_hi rise together.
- R4: In the drain phase, admit_block and drain_hi are high. ref_req is raised only while the rank's occupancy field is zero, so the drain lasts max(occupancy,1) cycles when the queue empties by one entry per cycle.
- R5: ref_req stays high until ref_ack is seen with it. After that, cmd_block and admit_block are high and drain_hi is low for max(busy_cycles,1) cycles.
- R6: When cmd_block falls, the rank spends exactly one cycle with all of its outputs low before it returns to idle.
- R7: Any number of refresh_due pulses that arrive during a running sequence collapse into one pending request. That request runs exactly one more full sequence after the recovery cycle.
- R8: Ranks are independent. A sequence on one rank leaves every output of the other ranks low.
- R9: The occupancy of rank i is rq_occ[i*OCC_W +: OCC_W]. A non-zero value in another rank's field does not delay the refresh of this rank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_due | input | NUM_RANKS | One-cycle refresh-due pulse per rank |
| extend_cycles | input | CNT_W | Length of the prefetch extension window |
| busy_cycles | input | CNT_W | Refresh busy time after acceptance |
| rq_occ | input | NUM_RANKS*OCC_W | Read-queue occupancy per rank |
| ref_ack | input | NUM_RANKS | Refresh accepted by the command issuer |
| stream_extend | output | NUM_RANKS | Let prefetch streams to the rank run ahead |
| admit_block | output | NUM_RANKS | Refuse new reads to the rank at queue entry |
| drain_hi | output | NUM_RANKS | Drain the rank's queued reads at high priority |
| ref_req | output | NUM_RANKS | Refresh request toward the command issuer |
| cmd_block | output | NUM_RANKS | Rank is refreshing; no read or write may be issued |

## Verification
The assertions check the ordering on every cycle: the extension never overlaps the gate, and drain follows straight after the extension. They also check that a request appears only while the gate and the drain are both active, that busy begins only on an accepted request with the gate held and drain off, and that the cycle after busy is quiet. Only the bench scenarios can show the cycle counts, which depend on the programmed values and the occupancy. The same holds for collapsing several pending pulses into one extra sequence, for holding the request against a late acknowledge, and for isolating ranks from each other's occupancy fields.

// File: rtl/refresh_read_sequencer.sv
module refresh_read_sequencer #(
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 8,
  parameter int OCC_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_RANKS-1:0]       refresh_due,
  input  logic [CNT_W-1:0]           extend_cycles,
  input  logic [CNT_W-1:0]           busy_cycles,
  input  logic [NUM_RANKS*OCC_W-1:0] rq_occ,
  input  logic [NUM_RANKS-1:0]       ref_ack,
  output logic [NUM_RANKS-1:0]       stream_extend,
  output logic [NUM_RANKS-1:0]       admit_block,
  output logic [NUM_RANKS-1:0]       drain_hi,
  output logic [NUM_RANKS-1:0]       ref_req,
  output logic [NUM_RANKS-1:0]       cmd_block
);

  typedef enum logic [2:0] {S_IDLE, S_EXTEND, S_GATE, S_REF, S_RECOVER} rank_st_t;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
    rank_st_t         st;
    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic             empty;
    logic             last;

    assign empty = (rq_occ[g*OCC_W +: OCC_W] == '0);
    assign last  = (cnt <= ONE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st   <= S_IDLE;
        cnt  <= '0;
        pend <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (refresh_due[g]) begin
              st  <= S_EXTEND;
              cnt <= extend_cycles;
            end
          end
          S_EXTEND: begin
            if (refresh_due[g]) pend <= 1'b1;
            if (last) st  <= S_GATE;
            else      cnt <= cnt - ONE;
          end
          S_GATE: begin
            if (refresh_due[g]) pend <= 1'b1;
            if (ref_req[g] && ref_ack[g]) begin
              st  <= S_REF;
              cnt <= busy_cycles;
            end
          end
          S_REF: begin
            if (refresh_due[g]) pend <= 1'b1;
            if (last) st  <= S_RECOVER;
            else      cnt <= cnt - ONE;
          end
          S_RECOVER: begin
            pend <= 1'b0;
            if (pend || refresh_due[g]) begin
              st  <= S_EXTEND;
              cnt <= extend_cycles;
            end else begin
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end

    assign stream_extend[g] = (st == S_EXTEND);
    assign drain_hi[g]      = (st == S_GATE);
    assign admit_block[g]   = (st == S_GATE) || (st == S_REF);
    assign ref_req[g]       = (st == S_GATE) && empty;
    assign cmd_block[g]     = (st == S_REF);
  end

endmodule

// File: rtl/refresh_read_sequencer_chk.sv
module refresh_read_sequencer_chk #(
  parameter int NUM_RANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_RANKS-1:0] ref_ack,
  input logic [NUM_RANKS-1:0] stream_extend,
  input logic [NUM_RANKS-1:0] admit_block,
  input logic [NUM_RANKS-1:0] drain_hi,
  input logic [NUM_RANKS-1:0] ref_req,
  input logic [NUM_RANKS-1:0] cmd_block
);

  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_chk
    a_r3_extend_open: assert property (@(posedge clk) disable iff (!rst_n)
      stream_extend[i] |-> !admit_block[i]);

    a_r3_drain_after_extend: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drain_hi[i]) |-> $past(stream_extend[i]));

    a_r4_req_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req[i] |-> (drain_hi[i] && admit_block[i]));

    a_r5_busy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_block[i]) |-> $past(ref_req[i] && ref_ack[i]));

    a_r5_busy_gated: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_block[i] |-> (admit_block[i] && !drain_hi[i] && !stream_extend[i]));

    a_r6_recover_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_block[i]) |-> (!admit_block[i] && !stream_extend[i] && !ref_req[i]));
  end

endmodule

bind refresh_read_sequencer refresh_read_sequencer_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .stream_extend(stream_extend),
  .admit_block(admit_block), .drain_hi(drain_hi), .ref_req(ref_req), .cmd_block(cmd_block)
);

// File: tb/refresh_read_sequencer_tb.sv
`timescale 1ns/100ps
module refresh_read_sequencer_tb;
  localparam int NR = 4, CW = 8, OW = 6;

  logic clk = 0, rst_n = 0;
  logic [NR-1:0] refresh_due = '0, ref_ack;
  logic [CW-1:0] extend_cycles = '0, busy_cycles = '0;
  logic [NR*OW-1:0] rq_occ;
  logic [NR-1:0] stream_extend, admit_block, drain_hi, ref_req, cmd_block;
  logic ack_en = 1;

  int occ_v [NR];
  int ce [NR], cd [NR], cb [NR], cg [NR], cr [NR], co [NR];
  logic [NR-1:0] prev_busy = '0;
  int checks = 0, errors = 0;

  // rank, extend, busy, initial occupancy
  localparam int VEC [4][4] = '{'{0, 3, 2, 4}, '{1, 0, 0, 0}, '{2, 5, 6, 1}, '{3, 1, 3, 2}};

  always #2.5 clk = ~clk;
  assign ref_ack = ref_req & {NR{ack_en}};

  always_comb
    for (int i = 0; i < NR; i++) rq_occ[i*OW +: OW] = OW'(occ_v[i]);

  refresh_read_sequencer #(.NUM_RANKS(NR), .CNT_W(CW), .OCC_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .refresh_due(refresh_due), .extend_cycles(extend_cycles),
    .busy_cycles(busy_cycles), .rq_occ(rq_occ), .ref_ack(ref_ack),
    .stream_extend(stream_extend), .admit_block(admit_block), .drain_hi(drain_hi),
    .ref_req(ref_req), .cmd_block(cmd_block));

  always @(negedge clk) begin
    for (int i = 0; i < NR; i++) begin
      ce[i] += int'(stream_extend[i]);
      cd[i] += int'(drain_hi[i]);
      cb[i] += int'(cmd_block[i]);
      cg[i] += int'(admit_block[i]);
      co[i] += int'(stream_extend[i] | admit_block[i] | drain_hi[i] | ref_req[i] | cmd_block[i]);
      if (prev_busy[i] && !cmd_block[i] && !stream_extend[i] && !admit_block[i] && !drain_hi[i] && !ref_req[i])
        cr[i] += 1;
      if (drain_hi[i] && occ_v[i] > 0) occ_v[i] -= 1;
    end
    prev_busy <= cmd_block;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < NR; i++) begin ce[i]=0; cd[i]=0; cb[i]=0; cg[i]=0; cr[i]=0; co[i]=0; end
  endtask

  task automatic pulse(int r);
    @(negedge clk); refresh_due[r] = 1'b1;
    @(negedge clk); refresh_due[r] = 1'b0;
  endtask

  function automatic int mx1(int v); return (v < 1) ? 1 : v; endfunction

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) occ_v[i] = 0;
    clr();
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", int'({stream_extend, admit_block, drain_hi, ref_req, cmd_block}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 outputs after reset", int'({stream_extend, admit_block, drain_hi, ref_req, cmd_block}), 0);

    for (int v = 0; v < 4; v++) begin
      int r = VEC[v][0], e = VEC[v][1], b = VEC[v][2], d = VEC[v][3];
      extend_cycles = CW'(e); busy_cycles = CW'(b); occ_v[r] = d;
      if (r == 1) occ_v[0] = 5;
      @(negedge clk); clr();
      refresh_due[r] = 1'b1;
      @(negedge clk); refresh_due[r] = 1'b0;
      chk("R2 extend starts next cycle", int'(stream_extend[r]), 1);
      repeat (e + d + b + 10) @(negedge clk);
      chk("R2 extend length", ce[r], mx1(e));
      chk("R4 drain length", cd[r], mx1(d));
      chk("R5 busy length", cb[r], mx1(b));
      chk("R3 gate spans drain and busy", cg[r], mx1(d) + mx1(b));
      chk("R6 one quiet recovery", cr[r], 1);
      for (int o = 0; o < NR; o++)
        if (o != r) chk("R8 other ranks untouched", co[o], 0);
      if (r == 1) begin
        chk("R9 other occupancy field ignored", occ_v[0], 5);
        occ_v[0] = 0;
      end
    end

    // R5: late acknowledge holds the request
    extend_cycles = 1; busy_cycles = 2; occ_v[2] = 0; ack_en = 0;
    @(negedge clk); clr();
    pulse(2);
    repeat (6) @(negedge clk);
    chk("R5 request held without ack", int'(ref_req[2]), 1);
    chk("R5 no busy without ack", cb[2], 0);
    chk("R4 drain held without ack", int'(drain_hi[2]), 1);
    ack_en = 1;
    repeat (8) @(negedge clk);
    chk("R5 busy after late ack", cb[2], 2);

    // R7: several pulses during a sequence collapse to one more
    extend_cycles = 4; busy_cycles = 2; occ_v[3] = 0;
    @(negedge clk); clr();
    refresh_due[3] = 1'b1;
    @(negedge clk); refresh_due[3] = 1'b0;
    @(negedge clk); refresh_due[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); refresh_due[3] = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 extend for two sequences", ce[3], 8);
    chk("R7 busy for two sequences", cb[3], 4);
    chk("R7 two recoveries", cr[3], 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule